// File: doc/BRIEF.md
# SPI Packet RAM Streaming Port

This block is the serial slave front end for a pair of packet memories, each 64 words of 16 bits: one holds outgoing frame data and one holds received frame data. A host pulls chip enable low and clocks in a header byte. The header gives the transfer direction and a register address. When that address names one of the packet memories, every byte that follows moves into or out of that memory. A word pointer inside the block advances by itself, so only one header is needed for a whole packet. The register address does not change during the burst.

The serial pins are brought into the system clock domain and sampled there. Writes pack byte pairs into words, high byte first, and always start at word 0. Reads first return one dummy word, then stream memory from word 0. At the end of a write burst the block records a 7-bit transmit length. This length is the stored payload bytes plus two bytes reserved for a checksum. A burst that runs past the last memory word raises a one-cycle strobe for a separate error block, and the rest of that burst has no effect.

Top module: `spi_pkt_ram_port`

## Requirements
- R1: Out of reset the block drives spi_miso, tx_we, rx_re, evt_addr_ovf and tx_len_upd low and tx_len to 0.
- R2: The first byte after chip enable falls is the header: bit 7 set means read, bit 6 is ignored, bits 5:0 are the address. Only a read of address 0x01 or a write of address 0x02 starts a memory burst. Any other header leaves the memories, tx_len and tx_len_upd untouched and keeps spi_miso low.
- R3: In a write burst each pair of data bytes becomes one word, with the first byte in bits 15:8. The words go to consecutive transmit memory addresses that begin at 0 in every transaction.
- R4: In a read burst the serial data is sent MSB first, changing after a falling edge of SCLK (mode 0). The byte returned during the header is 0x00. The first data word is 0x0000. After that come receive memory words 0, 1, 2 and so on, each high byte first.
- R5: When a write burst ends after an odd number of data bytes, the last byte is written as bits 15:8 of the next word with 0x00 in bits 7:0. This write happens in the cycle that detects chip enable rising.
- R6: In the cycle that detects chip enable rising after a write burst, tx_len_upd pulses for one cycle. From the next cycle tx_len holds the stored byte count plus 2, where stored bytes are capped at 128 and the sum is capped at 127. tx_len changes at no other time.
- R7: When a write burst reaches its 129th data byte, or a read burst needs memory word 64 (after 130 data bytes), evt_addr_ovf pulses once. After that the burst performs no memory access and spi_miso stays low until chip enable rises.
- R8: Chip enable rising ends a transaction and discards any partial byte. The next transaction parses a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial chip enable, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| tx_we | output | 1 | Transmit memory write enable |
| tx_addr | output | 6 | Transmit memory word address |
| tx_wdata | output | 16 | Transmit memory write word |
| rx_re | output | 1 | Receive memory read enable (data expected next cycle) |
| rx_addr | output | 6 | Receive memory word address |
| rx_rdata | input | 16 | Receive memory read word |
| tx_len | output | 7 | Transmit length: stored bytes plus 2 |
| tx_len_upd | output | 1 | One-cycle pulse when tx_len is updated |
| evt_addr_ovf | output | 1 | One-cycle address overflow strobe |

## Verification
Two actions fall into the same clock cycle when chip enable rises after an odd-length write: the write of the trailing partial word and the transmit length update. The bench ends write bursts with three bytes, and again after an abort in the middle of a byte. It counts the cycles in which tx_we and tx_len_upd are both high. It then checks the flushed word in its memory model and the new length value. A separate check at the word-64 boundary makes sure the overflow strobe never coincides with a memory access.

// File: rtl/spi_pr_pkg.sv
package spi_pr_pkg;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;

  // Header decode: bit 7 = read, bit 6 reserved, bits 5:0 = address.
  function automatic phase_e hdr_kind(input logic [7:0] h,
                                      input logic [5:0] rx_a,
                                      input logic [5:0] tx_a);
    if (h[7] && (h[5:0] == rx_a)) return PH_RD;
    if (!h[7] && (h[5:0] == tx_a)) return PH_WR;
    return PH_SKIP;
  endfunction

  // Word slot written by data byte number c (1-based).
  function automatic int wr_slot(input int c);
    return (c - 1) / 2;
  endfunction

  // Memory word sent after c data bytes have passed (-1 is the dummy word).
  function automatic int rd_slot(input int c);
    return (c / 2) - 1;
  endfunction

  // Transmit length: stored bytes plus two checksum bytes, saturated.
  function automatic int len_of(input int nbytes, input int depth, input int len_w);
    int stored;
    int sum;
    int maxv;
    stored = (nbytes > 2 * depth) ? 2 * depth : nbytes;
    sum    = stored + 2;
    maxv   = (1 << len_w) - 1;
    return (sum > maxv) ? maxv : sum;
  endfunction

endpackage

// File: rtl/spi_pr_sync.sv
module spi_pr_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[s] <= RST_VAL;
      end else if (s == 0) begin
        stg[s] <= din;
      end else begin
        stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_pr_deser.sv
module spi_pr_deser #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            shift_en,
  input  logic            din,
  output logic            byte_done,
  output logic [BITS-1:0] byte_val
);

  localparam int CW = $clog2(BITS);

  logic [CW-1:0]   bit_cnt;
  logic [BITS-2:0] sr;

  assign byte_val  = {sr, din};
  assign byte_done = shift_en && (bit_cnt == CW'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sr      <= '0;
    end else if (clear) begin
      bit_cnt <= '0;
    end else if (shift_en) begin
      sr      <= byte_val[BITS-2:0];
      bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_pkt_ram_port.sv
module spi_pkt_ram_port
  import spi_pr_pkg::*;
#(
  parameter int          RAM_AW      = 6,
  parameter int          LEN_W       = 7,
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  RX_REG_ADDR = 6'h01,
  parameter logic [5:0]  TX_REG_ADDR = 6'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              tx_we,
  output logic [RAM_AW-1:0] tx_addr,
  output logic [15:0]       tx_wdata,
  output logic              rx_re,
  output logic [RAM_AW-1:0] rx_addr,
  input  logic [15:0]       rx_rdata,
  output logic [LEN_W-1:0]  tx_len,
  output logic              tx_len_upd,
  output logic              evt_addr_ovf
);

  localparam int DEPTH = 1 << RAM_AW;
  localparam int CNT_W = RAM_AW + 3;

  logic cs_n_s, sclk_s, mosi_s;
  logic cs_n_p, sclk_p;
  logic sclk_rise, sclk_fall, cs_rise;
  logic       byte_done;
  logic [7:0] byte_val;

  spi_pr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_cs_n, spi_sclk, spi_mosi}),
    .dout ({cs_n_s, sclk_s, mosi_s})
  );

  assign sclk_rise = !cs_n_s && sclk_s && !sclk_p;
  assign sclk_fall = !cs_n_s && !sclk_s && sclk_p;
  assign cs_rise   = cs_n_s && !cs_n_p;

  spi_pr_deser #(.BITS(8)) deser_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cs_n_s),
    .shift_en (sclk_rise),
    .din      (mosi_s),
    .byte_done(byte_done),
    .byte_val (byte_val)
  );

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic              ovf_q;
  logic [7:0]        hi_hold;
  logic [15:0]       rd_hold;
  logic [15:0]       cur_word;
  logic              re_q;
  logic              load_pend;
  logic [7:0]        miso_sr;

  // Named internal events, used by the checker.
  logic wr_word, wr_flush, rd_fetch, ovf_evt, rd_active;
  logic [15:0] word_pick;
  int c_now, c_next, slot_w, slot_r, slot_f, slot_s;

  always_comb begin
    c_now  = int'(cnt);
    c_next = c_now + 1;
    slot_w = wr_slot(c_next);
    slot_r = rd_slot(c_next);
    slot_f = wr_slot(c_now);
    slot_s = rd_slot(c_now);
  end

  assign rd_active = (phase == PH_RD);

  assign wr_word  = (phase == PH_WR) && byte_done && !c_next[0] && !ovf_q && (slot_w < DEPTH);
  assign wr_flush = cs_rise && (phase == PH_WR) && c_now[0] && (slot_f < DEPTH);
  assign rd_fetch = rd_active && byte_done && !c_next[0] && !ovf_q &&
                    (slot_r >= 0) && (slot_r < DEPTH);
  assign ovf_evt  = !ovf_q && byte_done &&
                    (((phase == PH_WR) && c_next[0] && (slot_w >= DEPTH)) ||
                     (rd_active && !c_next[0] && (slot_r >= DEPTH)));

  assign word_pick = ((slot_s >= 0) && (slot_s < DEPTH) && !ovf_q) ? rd_hold : 16'h0000;

  assign tx_we        = wr_word || wr_flush;
  assign tx_addr      = RAM_AW'(wr_flush ? slot_f : slot_w);
  assign tx_wdata     = wr_flush ? {hi_hold, 8'h00} : {hi_hold, byte_val};
  assign rx_re        = rd_fetch;
  assign rx_addr      = RAM_AW'(slot_r);
  assign evt_addr_ovf = ovf_evt;
  assign tx_len_upd   = cs_rise && (phase == PH_WR);
  assign spi_miso     = miso_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_p    <= 1'b1;
      sclk_p    <= 1'b0;
      phase     <= PH_HDR;
      cnt       <= '0;
      ovf_q     <= 1'b0;
      hi_hold   <= '0;
      rd_hold   <= '0;
      cur_word  <= '0;
      re_q      <= 1'b0;
      load_pend <= 1'b0;
      miso_sr   <= '0;
      tx_len    <= '0;
    end else begin
      cs_n_p <= cs_n_s;
      sclk_p <= sclk_s;
      re_q   <= rd_fetch;
      if (re_q) rd_hold <= rx_rdata;
      if (tx_len_upd) tx_len <= LEN_W'(len_of(c_now, DEPTH, LEN_W));
      if (cs_n_s) begin
        phase     <= PH_HDR;
        cnt       <= '0;
        ovf_q     <= 1'b0;
        load_pend <= 1'b0;
        miso_sr   <= '0;
      end else begin
        if (ovf_evt) ovf_q <= 1'b1;
        if (byte_done) begin
          if (phase == PH_HDR) begin
            phase     <= hdr_kind(byte_val, RX_REG_ADDR, TX_REG_ADDR);
            load_pend <= (hdr_kind(byte_val, RX_REG_ADDR, TX_REG_ADDR) == PH_RD);
          end else if (phase != PH_SKIP) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (rd_active) load_pend <= 1'b1;
            if ((phase == PH_WR) && c_next[0]) hi_hold <= byte_val;
          end
        end
        if (sclk_fall) begin
          if (load_pend) begin
            load_pend <= 1'b0;
            if (!c_now[0]) begin
              cur_word <= word_pick;
              miso_sr  <= word_pick[15:8];
            end else begin
              miso_sr  <= cur_word[7:0];
            end
          end else begin
            miso_sr <= {miso_sr[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_pkt_ram_port_chk.sv
module spi_pkt_ram_port_chk #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_we,
  input logic             rx_re,
  input logic             evt_addr_ovf,
  input logic [LEN_W-1:0] tx_len,
  input logic             tx_len_upd,
  input logic             rd_active
);

  // R7
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_addr_ovf |=> !evt_addr_ovf);

  // R7
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_addr_ovf |-> (!tx_we && !rx_re));

  // R4
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_re |=> !rx_re);

  // R2
  rd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_re |-> rd_active);

  // R3
  wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |=> !tx_we);

  // R6
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_len_upd |=> $stable(tx_len));

endmodule

bind spi_pkt_ram_port spi_pkt_ram_port_chk #(.LEN_W(LEN_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_we       (tx_we),
  .rx_re       (rx_re),
  .evt_addr_ovf(evt_addr_ovf),
  .tx_len      (tx_len),
  .tx_len_upd  (tx_len_upd),
  .rd_active   (rd_active)
);

// File: tb/spi_pkt_ram_port_tb_top.sv
`timescale 1ns/1ps
module spi_pkt_ram_port_tb_top;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic        tx_we;
  logic [5:0]  tx_addr;
  logic [15:0] tx_wdata;
  logic        rx_re;
  logic [5:0]  rx_addr;
  logic [15:0] rx_rdata = '0;
  logic [6:0]  tx_len;
  logic        tx_len_upd;
  logic        evt_addr_ovf;

  always #10 clk = ~clk;

  spi_pkt_ram_port dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .tx_we(tx_we), .tx_addr(tx_addr),
    .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_addr(rx_addr), .rx_rdata(rx_rdata),
    .tx_len(tx_len), .tx_len_upd(tx_len_upd), .evt_addr_ovf(evt_addr_ovf)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'hC35A ^ 16'(i * 16'h0123);
  endfunction

  logic [15:0] tx_mem [64];
  int n_we = 0, n_re = 0, n_ovf = 0, n_upd = 0, n_same = 0;
  int n_checks = 0, n_fail = 0;

  always @(posedge clk) begin
    if (tx_we) tx_mem[tx_addr] <= tx_wdata;
    if (rx_re) rx_rdata <= pat(int'(rx_addr));
    if (rst_n) begin
      if (tx_we) n_we++;
      if (rx_re) n_re++;
      if (evt_addr_ovf) n_ovf++;
      if (tx_len_upd) n_upd++;
      if (tx_len_upd && tx_we) n_same++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic t_reset();
    chk("R1 miso", 32'(spi_miso), 0);
    chk("R1 tx_we", 32'(tx_we), 0);
    chk("R1 rx_re", 32'(rx_re), 0);
    chk("R1 ovf", 32'(evt_addr_ovf), 0);
    chk("R1 upd", 32'(tx_len_upd), 0);
    chk("R1 tx_len", 32'(tx_len), 0);
  endtask

  task automatic t_write_basic();
    logic [7:0] r;
    int we0 = n_we, up0 = n_upd;
    cs_begin();
    spi_byte(8'h02, r);
    for (int k = 0; k < 5; k++) begin
      spi_byte(8'h11 + 8'(k), r);
      spi_byte(8'hA0 + 8'(k), r);
    end
    cs_end();
    chk("R3 write count", 32'(n_we - we0), 5);
    for (int k = 0; k < 5; k++)
      chk("R3 word", 32'(tx_mem[k]), 32'({8'h11 + 8'(k), 8'hA0 + 8'(k)}));
    chk("R6 len 10 bytes", 32'(tx_len), 12);
    chk("R6 upd pulse", 32'(n_upd - up0), 1);
  endtask

  task automatic t_write_restart();
    logic [7:0] r;
    cs_begin();
    spi_byte(8'h02, r);
    spi_byte(8'h77, r); spi_byte(8'h66, r);
    spi_byte(8'h55, r); spi_byte(8'h44, r);
    cs_end();
    chk("R3 restart w0", 32'(tx_mem[0]), 32'h7766);
    chk("R3 restart w1", 32'(tx_mem[1]), 32'h5544);
    chk("R3 restart w2 kept", 32'(tx_mem[2]), 32'h13A2);
    chk("R6 len 4 bytes", 32'(tx_len), 6);
  endtask

  task automatic t_odd();
    logic [7:0] r;
    int s0 = n_same;
    cs_begin();
    spi_byte(8'h02, r);
    spi_byte(8'hAB, r); spi_byte(8'hCD, r); spi_byte(8'hEF, r);
    cs_end();
    chk("R5 w0", 32'(tx_mem[0]), 32'hABCD);
    chk("R5 flush", 32'(tx_mem[1]), 32'hEF00);
    chk("R6 len odd", 32'(tx_len), 5);
    chk("R5 flush with upd", 32'(n_same - s0), 1);
  endtask

  task automatic t_read(input logic [7:0] hdr, input string tag);
    logic [7:0] hi, lo, r;
    cs_begin();
    spi_byte(hdr, r);
    chk({tag, " hdr byte"}, 32'(r), 0);
    spi_byte(8'h00, hi); spi_byte(8'h00, lo);
    chk({tag, " dummy"}, 32'({hi, lo}), 0);
    for (int k = 0; k < 4; k++) begin
      spi_byte(8'h00, hi); spi_byte(8'h00, lo);
      chk({tag, " word"}, 32'({hi, lo}), 32'(pat(k)));
    end
    cs_end();
  endtask

  task automatic t_ignored();
    logic [7:0] r;
    logic [7:0] acc;
    int we0 = n_we, up0 = n_upd, re0 = n_re;
    logic [6:0] len0 = tx_len;
    cs_begin();
    spi_byte(8'h01, r);
    spi_byte(8'h12, r); spi_byte(8'h34, r);
    cs_end();
    cs_begin();
    spi_byte(8'h05, r);
    spi_byte(8'h56, r); spi_byte(8'h78, r);
    cs_end();
    acc = '0;
    cs_begin();
    spi_byte(8'h82, r);
    for (int k = 0; k < 4; k++) begin
      spi_byte(8'hFF, r);
      acc = acc | r;
    end
    cs_end();
    chk("R2 no tx write", 32'(n_we - we0), 0);
    chk("R2 no upd", 32'(n_upd - up0), 0);
    chk("R2 len kept", 32'(tx_len), 32'(len0));
    chk("R2 no rx read", 32'(n_re - re0), 0);
    chk("R2 miso low", 32'(acc), 0);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    cs_begin();
    spi_byte(8'h02, r);
    spi_byte(8'h12, r); spi_byte(8'h34, r); spi_byte(8'h56, r);
    spi_bits(8'hFF, 4, r);
    cs_end();
    chk("R8 w0", 32'(tx_mem[0]), 32'h1234);
    chk("R8 partial dropped", 32'(tx_mem[1]), 32'h5600);
    chk("R8 len", 32'(tx_len), 5);
    cs_begin();
    spi_byte(8'h02, r);
    spi_byte(8'h9A, r); spi_byte(8'hBC, r);
    cs_end();
    chk("R8 new header", 32'(tx_mem[0]), 32'h9ABC);
    chk("R8 new len", 32'(tx_len), 4);
  endtask

  task automatic t_ovf_write();
    logic [7:0] r;
    int we0 = n_we, ov0 = n_ovf;
    cs_begin();
    spi_byte(8'h02, r);
    for (int i = 0; i < 130; i++) spi_byte(8'(i) ^ 8'h5A, r);
    cs_end();
    chk("R7 writes capped", 32'(n_we - we0), 64);
    chk("R7 one strobe wr", 32'(n_ovf - ov0), 1);
    chk("R7 last word", 32'(tx_mem[63]), 32'({8'(126) ^ 8'h5A, 8'(127) ^ 8'h5A}));
    chk("R6 len saturated", 32'(tx_len), 127);
  endtask

  task automatic t_ovf_read();
    logic [7:0] hi, lo, r;
    int re0 = n_re, ov0 = n_ovf;
    cs_begin();
    spi_byte(8'h81, r);
    for (int w = 0; w < 66; w++) begin
      spi_byte(8'h00, hi); spi_byte(8'h00, lo);
      if (w == 64) chk("R4 word 63", 32'({hi, lo}), 32'(pat(63)));
      if (w == 65) chk("R7 miso low after ovf", 32'({hi, lo}), 0);
    end
    cs_end();
    chk("R7 reads capped", 32'(n_re - re0), 64);
    chk("R7 one strobe rd", 32'(n_ovf - ov0), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_basic();
    t_write_restart();
    t_odd();
    t_read(8'h81, "R4");
    t_read(8'hC1, "R2 bit6");
    t_ignored();
    t_abort();
    t_ovf_write();
    t_ovf_read();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule